// File: doc/BRIEF.md
# Configurable Output Logic Cell

This block is one output cell of a sum-of-products logic array. It receives the OR-sum computed by the array for this output. It also receives a product term that decides whether the pin driver is on, and two terms shared across all cells: a synchronous set and an asynchronous clear. Two static configuration inputs shape the cell. One routes the sum either through a D flip-flop or straight past it. The other optionally inverts the value before it reaches the pin driver.

The cell returns one feedback bit to the array. In registered mode the feedback is the flip-flop state, taken before the polarity stage. In combinatorial mode the feedback is the value actually present on the pin. When the driver is off, that value comes from the outside world, so the pin serves as an input.

Because simulation of true tri-states is awkward at the block boundary, the pin is modelled by three signals: the driver enable, the driven value, and the resolved pin value. A deasserted enable stands for high impedance, and the resolved value then equals the external stimulus. There is no streaming data path, so every port is a plain level signal with no valid/ready handshake.

Top module: `pal_out_cell`

## Requirements
- R1: With `cfg_registered`=1, the flip-flop loads `sum_in` on each rising `clk` edge when neither shared term is active, and `fb_out` shows the loaded value after that edge.
- R2: With `cfg_registered`=0, `pin_drive` follows `sum_in` (XOR `cfg_invert`) in the same cycle, with no clock edge needed.
- R3: `cfg_invert`=1 makes `pin_drive` the complement of the selected path value; `cfg_invert`=0 passes it unchanged.
- R4: `pin_oe` equals `oe_term`. When `pin_oe`=0 (high impedance), `pin_value` equals `pin_ext`; when `pin_oe`=1, `pin_value` equals `pin_drive`.
- R5: In registered mode, `fb_out` equals the flip-flop state regardless of `oe_term` and `pin_ext`.
- R6: In combinatorial mode, `fb_out` equals `pin_value`, which is the external value when the driver is off.
- R7: `async_clr`=1 clears the flip-flop at once, without waiting for a clock edge.
- R8: `sync_set`=1 sets the flip-flop to 1 at the next rising edge and not before.
- R9: When `async_clr` and `sync_set` are both active across an edge, the flip-flop stays 0.
- R10: While `por_n`=0, the flip-flop is 0, so registered-mode `fb_out` is 0.
- R11: Registered feedback is taken before the polarity stage: with `cfg_invert`=1, `fb_out` is the uninverted flip-flop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, rising edge |
| por_n | input | 1 | Power-on clear, active low, asynchronous |
| sum_in | input | 1 | OR-sum from the array |
| oe_term | input | 1 | Output-enable product term |
| sync_set | input | 1 | Shared synchronous set term |
| async_clr | input | 1 | Shared asynchronous clear term |
| cfg_registered | input | 1 | 1 = registered path, 0 = combinatorial path |
| cfg_invert | input | 1 | 1 = invert before the pin driver |
| pin_ext | input | 1 | External value seen on the pin when not driven |
| pin_oe | output | 1 | Pin driver enable (0 = high impedance) |
| pin_drive | output | 1 | Value the driver would put on the pin |
| pin_value | output | 1 | Resolved pin value |
| fb_out | output | 1 | Feedback bit returned to the array |

## Verification
The hardest situations to reach are the timing interactions of the shared terms. One is a clear that lands between edges and must act before any clock arrives. The other is a clear held together with a set across an edge, where the clear must win. The stimulus drives both terms at the falling edge, samples the feedback before the next rising edge to catch an early or late change, and then holds both through an edge. Registered mode is also checked with the driver off and a contrary external value, which shows that the feedback ignores the pin.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;
  typedef enum logic {
    PATH_COMB = 1'b0,
    PATH_REG  = 1'b1
  } path_mode_t;

  localparam logic CLEAR_LEVEL = 1'b0;
  localparam logic SET_LEVEL   = 1'b1;
endpackage

// File: rtl/pal_mc_store.sv
module pal_mc_store
  import pal_mc_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic async_clr,
  input  logic sync_set,
  input  logic d_in,
  output logic q_out
);
  logic clr_any;
  assign clr_any = async_clr | ~por_n;

  always_ff @(posedge clk or posedge clr_any) begin
    if (clr_any)       q_out <= CLEAR_LEVEL;
    else if (sync_set) q_out <= SET_LEVEL;
    else               q_out <= d_in;
  end

  // R1: plain capture when no shared term is active
  assert_capture_R1: assert property (@(posedge clk) disable iff (clr_any)
    (!sync_set) |=> (q_out == $past(d_in)));

  // R8: set term lands at the following edge
  assert_set_next_edge_R8: assert property (@(posedge clk) disable iff (clr_any)
    sync_set |=> q_out);

  // R7 / R9: clear dominates, including over a concurrent set
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!por_n)
    async_clr |-> (q_out == CLEAR_LEVEL));
endmodule

// File: rtl/pal_mc_drive.sv
module pal_mc_drive
  import pal_mc_pkg::*;
(
  input  path_mode_t mode,
  input  logic       invert,
  input  logic       q_in,
  input  logic       sum_in,
  input  logic       oe_term,
  input  logic       pin_ext,
  output logic       pin_oe,
  output logic       pin_drive,
  output logic       pin_value
);
  logic path_val;

  always_comb begin
    path_val  = (mode == PATH_REG) ? q_in : sum_in;
    pin_drive = invert ? ~path_val : path_val;
    pin_oe    = oe_term;
    pin_value = pin_oe ? pin_drive : pin_ext;
  end
endmodule

// File: rtl/pal_mc_fbsel.sv
module pal_mc_fbsel
  import pal_mc_pkg::*;
(
  input  path_mode_t mode,
  input  logic       q_in,
  input  logic       pin_value,
  output logic       fb_out
);
  always_comb begin
    unique case (mode)
      PATH_REG:  fb_out = q_in;
      PATH_COMB: fb_out = pin_value;
      default:   fb_out = q_in;
    endcase
  end
endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell
  import pal_mc_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic sum_in,
  input  logic oe_term,
  input  logic sync_set,
  input  logic async_clr,
  input  logic cfg_registered,
  input  logic cfg_invert,
  input  logic pin_ext,
  output logic pin_oe,
  output logic pin_drive,
  output logic pin_value,
  output logic fb_out
);
  path_mode_t mode;
  logic       q;

  assign mode = cfg_registered ? PATH_REG : PATH_COMB;

  pal_mc_store u_store (
    .clk       (clk),
    .por_n     (por_n),
    .async_clr (async_clr),
    .sync_set  (sync_set),
    .d_in      (sum_in),
    .q_out     (q)
  );

  pal_mc_drive u_drive (
    .mode      (mode),
    .invert    (cfg_invert),
    .q_in      (q),
    .sum_in    (sum_in),
    .oe_term   (oe_term),
    .pin_ext   (pin_ext),
    .pin_oe    (pin_oe),
    .pin_drive (pin_drive),
    .pin_value (pin_value)
  );

  pal_mc_fbsel u_fbsel (
    .mode      (mode),
    .q_in      (q),
    .pin_value (pin_value),
    .fb_out    (fb_out)
  );

  // R6: undriven pin in combinatorial mode feeds the outside value back
  assert_comb_fb_ext_R6: assert property (@(posedge clk) disable iff (!por_n)
    (!cfg_registered && !oe_term) |-> (fb_out == pin_ext));

  // R3: driven combinatorial pin carries the sum with the chosen polarity
  assert_polarity_R3: assert property (@(posedge clk) disable iff (!por_n)
    (!cfg_registered && oe_term) |-> (pin_value == (sum_in ^ cfg_invert)));

  // R5: registered feedback is the captured sum, independent of the pin
  assert_reg_fb_R5: assert property (@(posedge clk) disable iff (!por_n || async_clr)
    (cfg_registered && !sync_set) |=> (!cfg_registered || fb_out == $past(sum_in)));
endmodule

// File: tb/pal_out_cell_tb_top.sv
module pal_out_cell_tb_top;
  logic clk = 1'b0;
  logic por_n, sum_in, oe_term, sync_set, async_clr;
  logic cfg_registered, cfg_invert, pin_ext;
  logic pin_oe, pin_drive, pin_value, fb_out;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  pal_out_cell dut_i (
    .clk(clk), .por_n(por_n), .sum_in(sum_in), .oe_term(oe_term),
    .sync_set(sync_set), .async_clr(async_clr),
    .cfg_registered(cfg_registered), .cfg_invert(cfg_invert),
    .pin_ext(pin_ext), .pin_oe(pin_oe), .pin_drive(pin_drive),
    .pin_value(pin_value), .fb_out(fb_out)
  );

  // {invert, oe, sum, ext, exp_value, exp_fb, exp_oe}
  localparam logic [6:0] COMB_VEC [8] = '{
    7'b0101_001, 7'b0110_111, 7'b1100_111, 7'b1111_001,
    7'b0010_000, 7'b0001_110, 7'b1011_110, 7'b1000_000
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    por_n = 0; sum_in = 1; oe_term = 1; sync_set = 0; async_clr = 0;
    cfg_registered = 1; cfg_invert = 0; pin_ext = 0;
    repeat (2) @(posedge clk);
    #2;
    chk("R10 power-up clear fb", fb_out, 1'b0);
    @(negedge clk); por_n = 1;

    // combinatorial vector table: R2 R3 R4 R6
    cfg_registered = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {cfg_invert, oe_term, sum_in, pin_ext} = COMB_VEC[i][6:3];
      #1;
      chk($sformatf("R4 vec%0d pin_value", i), pin_value, COMB_VEC[i][2]);
      chk($sformatf("R6 vec%0d fb", i), fb_out, COMB_VEC[i][1]);
      chk($sformatf("R4 vec%0d pin_oe", i), pin_oe, COMB_VEC[i][0]);
      chk($sformatf("R3 R2 vec%0d pin_drive", i), pin_drive,
          COMB_VEC[i][4] ^ COMB_VEC[i][6]);
    end

    // registered path R1
    @(negedge clk);
    cfg_registered = 1; cfg_invert = 0; oe_term = 1; sum_in = 0;
    @(posedge clk); #2;
    chk("R1 load 0", fb_out, 1'b0);
    @(negedge clk); sum_in = 1; #1;
    chk("R1 no change before edge", fb_out, 1'b0);
    @(posedge clk); #2;
    chk("R1 load 1 fb", fb_out, 1'b1);
    chk("R1 load 1 pin", pin_value, 1'b1);

    // R11 polarity after the flop, feedback before it
    @(negedge clk); cfg_invert = 1; #1;
    chk("R11 fb uninverted", fb_out, 1'b1);
    chk("R3 registered pin inverted", pin_value, 1'b0);

    // R5 pin released, contrary external value
    @(negedge clk); oe_term = 0; pin_ext = 0; #1;
    chk("R5 fb ignores pin", fb_out, 1'b1);
    chk("R4 released pin_oe", pin_oe, 1'b0);
    chk("R4 released pin_value", pin_value, 1'b0);

    // R8 synchronous set
    @(negedge clk); cfg_invert = 0; oe_term = 1; sum_in = 0;
    @(posedge clk); #2;
    chk("R1 reload 0", fb_out, 1'b0);
    @(negedge clk); sync_set = 1; #1;
    chk("R8 not before edge", fb_out, 1'b0);
    @(posedge clk); #2;
    chk("R8 set at edge", fb_out, 1'b1);

    // R7 asynchronous clear mid-cycle
    @(negedge clk); sync_set = 0; sum_in = 1; #3;
    async_clr = 1; #1;
    chk("R7 clear without edge", fb_out, 1'b0);

    // R9 clear and set together across an edge
    sync_set = 1;
    @(posedge clk); #2;
    chk("R9 clear beats set", fb_out, 1'b0);
    @(negedge clk); async_clr = 0; sync_set = 0; sum_in = 1;
    @(posedge clk); #2;
    chk("R1 resumes after clear", fb_out, 1'b1);

    // R10 power-on clear reasserted
    @(negedge clk); por_n = 0; #1;
    chk("R10 por clears", fb_out, 1'b0);
    @(negedge clk); por_n = 1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule